// File: doc/BRIEF.md
# Temperature-Indexed Wiper Controller

This block produces a 7-bit wiper code for a digital potentiometer. In direct mode the code changes only through bus writes and takes the initial value at reset. In the two table-driven modes, every temperature sample that arrives on the sample-valid strobe selects one of 36 table entries. Each entry covers a 4-degree window, and the window choice carries one degree of hysteresis that depends on the direction of change. The chosen entry is then either copied to the wiper or added as a signed offset to the initial value, with the sum saturated.

Control inputs can freeze the automatic wiper loads, freeze the automatic table-address updates, or put the block in standby. While the wiper is frozen, the bus may write it. While the address is frozen, the bus may write the address, so that each table entry can be applied in turn. A write port and a read port give a bus interface access to the table contents.

Top module: `lut_wiper_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, `wiper_q` loads `init_val`, `addr_q` loads 0 and every table entry clears to 0. The first sample accepted after reset sets the address directly to the base window.
- R2: With `cfg_lut_en` = 0, accepted bus writes (`wiper_wr_en`) load `wiper_q` on the next edge. Temperature samples change neither `wiper_q` nor `addr_q`.
- R3: The base window for sample T (signed, 1 degree per LSB) is floor((T+40)/4), clamped to 0..35. `addr_q` never exceeds 35.
- R4: While the temperature rises, the window moves up as soon as the base window exceeds the current one, which happens at a window's even lower edge L. While it falls, the window leaves window i only when T drops below L-1. T = L-1 therefore keeps window i when approached from above.
- R5: With `cfg_lut_en` = 1 and `cfg_adder` = 0, an accepted sample loads `wiper_q` with the selected entry on the same edge. Entries above 7Fh load 7Fh.
- R6: With `cfg_lut_en` = 1 and `cfg_adder` = 1, the entry is read as signed two's complement and added to `init_val`. The sum saturates to 0..127.
- R7: With `cfg_wiper_hold` = 1, samples do not load the wiper and bus writes to it are accepted. In a table-driven mode with the hold clear, bus writes to the wiper are ignored.
- R8: With `cfg_addr_hold` = 1, `addr_q` does not follow the temperature. Bus writes of values 0..35 load it, writes above 35 are ignored, and wiper loads use the held address. Bus address writes are ignored while the hold is clear.
- R9: With `cfg_standby` = 1, samples change neither `addr_q` nor `wiper_q`. After standby clears, nothing changes until the next accepted sample, which updates normally.
- R10: A table write to index 0..35 stores the byte; an index above 35 is ignored. The read port returns the stored byte, or 0 for an index above 35.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_lut_en | input | 1 | 1 = table-driven modes, 0 = direct |
| cfg_adder | input | 1 | In table modes, 1 = signed offset added to initial value |
| cfg_wiper_hold | input | 1 | Freeze automatic wiper loads, allow bus wiper writes |
| cfg_addr_hold | input | 1 | Freeze automatic address updates, allow bus address writes |
| cfg_standby | input | 1 | Ignore temperature samples |
| init_val | input | 7 | Initial / base wiper value |
| temp_valid | input | 1 | One-cycle strobe: a conversion finished |
| temp_sample | input | 8 | Signed temperature, 1 degree per LSB |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_idx | input | 6 | Table write index |
| tbl_wr_data | input | 8 | Table write byte |
| tbl_rd_idx | input | 6 | Table read index |
| tbl_rd_data | output | 8 | Table read byte (combinational) |
| addr_wr_en | input | 1 | Bus write strobe for the address register |
| addr_wr_data | input | 6 | Bus write value for the address register |
| addr_q | output | 6 | Current table address |
| wiper_wr_en | input | 1 | Bus write strobe for the wiper register |
| wiper_wr_data | input | 7 | Bus write value for the wiper register |
| wiper_q | output | 7 | Current wiper code |

## Verification
On every cycle the assertions check these properties: the address stays within the table, the wiper and address hold still when a hold, standby or direct mode forbids a change and no bus write arrives, and a hysteresis step never leaves the span between the current and base windows. Only the directed scenarios show the actual values. These include the window edges while rising and falling, clamping at both temperature extremes, saturation of the signed offset at 0 and 127, the clipping of plain entries, and the fact that the first sample after standby clears is what updates the outputs.

// File: rtl/lut_wiper_pkg.sv
// Package: lut_wiper_pkg
// Shared mode type and decode for the temperature-indexed wiper controller.
// Assumes two configuration bits: a table-enable bit and an adder bit.
package lut_wiper_pkg;

    typedef enum logic [1:0] {
        MODE_DIRECT = 2'd0,
        MODE_TABLE  = 2'd1,
        MODE_OFFSET = 2'd2
    } wiper_mode_t;

    // Map the two configuration bits onto an operating mode.
    function automatic wiper_mode_t decode_mode(input logic lut_en, input logic adder);
        if (!lut_en)
            return MODE_DIRECT;
        else if (adder)
            return MODE_OFFSET;
        else
            return MODE_TABLE;
    endfunction

endpackage

// File: rtl/win_tracker.sv
// Module: win_tracker
// Turns a signed temperature sample into a table window index, with one
// degree of hysteresis that depends on the direction of change.
// Assumes windows of 2**WIN_SHIFT degrees starting at -TEMP_OFS.
// Purely combinational; the clock and reset feed only the assertion.
module win_tracker #(
    parameter int TEMP_W    = 8,
    parameter int DEPTH     = 36,
    parameter int WIN_SHIFT = 2,
    parameter int TEMP_OFS  = 40,
    localparam int IDX_W    = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [TEMP_W-1:0] temp_i,
    input  logic [IDX_W-1:0]         cur_idx_i,
    input  logic                     seen_i,
    output logic [IDX_W-1:0]         next_idx_o
);
    localparam int SW = TEMP_W + 2;

    logic signed [SW-1:0] shifted_lo;
    logic signed [SW-1:0] shifted_hi;
    logic [IDX_W-1:0]     base_idx;
    logic [IDX_W-1:0]     fall_idx;

    // Clamp a shifted temperature to a valid window index.
    function automatic logic [IDX_W-1:0] clamp_idx(input logic signed [SW-1:0] s);
        logic signed [SW-1:0] q;
        q = s >>> WIN_SHIFT;
        if (s < 0)
            return '0;
        else if (q > SW'(DEPTH - 1))
            return IDX_W'(DEPTH - 1);
        else
            return q[IDX_W-1:0];
    endfunction

    // Base window and the lower-threshold window used while falling.
    always_comb begin
        shifted_lo = SW'(temp_i) + SW'(TEMP_OFS);
        shifted_hi = shifted_lo + SW'(1);
        base_idx   = clamp_idx(shifted_lo);
        fall_idx   = clamp_idx(shifted_hi);
    end

    // Direction-dependent choice of the next window.
    always_comb begin
        if (!seen_i)
            next_idx_o = base_idx;
        else if (base_idx > cur_idx_i)
            next_idx_o = base_idx;
        else if (base_idx < cur_idx_i)
            next_idx_o = fall_idx;
        else
            next_idx_o = cur_idx_i;
    end

    // R4: a step never leaves the span between the current and base windows
    assert_hyst_span_R4: assert property (@(posedge clk) disable iff (!rst_n)
        seen_i |-> ((next_idx_o >= ((base_idx < cur_idx_i) ? base_idx : cur_idx_i)) &&
                    (next_idx_o <= ((base_idx > cur_idx_i) ? base_idx : cur_idx_i))));

endmodule

// File: rtl/lut_store.sv
// Module: lut_store
// Register-based table of DEPTH entries with one write port and two
// combinational read ports (bus read and wiper lookup).
// Assumes indices at or above DEPTH are invalid: writes to them are
// dropped and reads of them return zero.
module lut_store #(
    parameter int DEPTH     = 36,
    parameter int ENTRY_W   = 8,
    localparam int IDX_W    = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [ENTRY_W-1:0] wr_data,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [ENTRY_W-1:0] rd_data,
    input  logic [IDX_W-1:0]   lk_idx,
    output logic [ENTRY_W-1:0] lk_data
);
    logic [ENTRY_W-1:0] entry_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        // One table entry: cleared by reset, loaded when its index is written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                entry_q[g] <= '0;
            else if (wr_en && (wr_idx == IDX_W'(g)))
                entry_q[g] <= wr_data;
        end
    end

    // Bus read port with out-of-range guard.
    always_comb begin
        rd_data = '0;
        if (int'(rd_idx) < DEPTH)
            rd_data = entry_q[rd_idx];
    end

    // Lookup read port with out-of-range guard.
    always_comb begin
        lk_data = '0;
        if (int'(lk_idx) < DEPTH)
            lk_data = entry_q[lk_idx];
    end

endmodule

// File: rtl/wiper_calc.sv
// Module: wiper_calc
// Forms the wiper code from a table entry. In table mode the entry is
// unsigned and clipped to the wiper range. In offset mode the entry is
// signed and is added to the base value, and the sum saturates.
// Assumes ENTRY_W >= WIPER_W.
module wiper_calc
    import lut_wiper_pkg::*;
#(
    parameter int WIPER_W = 7,
    parameter int ENTRY_W = 8
) (
    input  wiper_mode_t        mode_i,
    input  logic [ENTRY_W-1:0] entry_i,
    input  logic [WIPER_W-1:0] base_i,
    output logic [WIPER_W-1:0] value_o
);
    localparam int SUM_W = ((ENTRY_W > WIPER_W) ? ENTRY_W : WIPER_W) + 2;
    localparam logic [WIPER_W-1:0] WMAX = '1;

    logic signed [SUM_W-1:0] sum;

    // Signed entry plus zero-extended base.
    always_comb begin
        sum = SUM_W'($signed(entry_i)) + $signed({2'b00, SUM_W'(base_i)});
    end

    // Mode-dependent clip or saturation.
    always_comb begin
        if (mode_i == MODE_OFFSET) begin
            if (sum < 0)
                value_o = '0;
            else if (sum > $signed(SUM_W'(WMAX)))
                value_o = WMAX;
            else
                value_o = sum[WIPER_W-1:0];
        end else begin
            if (entry_i > ENTRY_W'(WMAX))
                value_o = WMAX;
            else
                value_o = entry_i[WIPER_W-1:0];
        end
    end

endmodule

// File: rtl/lut_wiper_ctrl.sv
// Module: lut_wiper_ctrl
// Temperature-indexed wiper controller. It holds the table address
// register, the wiper register and a flag for the first accepted sample.
// Each accepted temperature sample updates the address and loads the wiper
// on the same edge, unless a hold or standby forbids it.
// Assumes temp_valid is a one-cycle strobe per conversion.
module lut_wiper_ctrl
    import lut_wiper_pkg::*;
#(
    parameter int TEMP_W    = 8,
    parameter int WIPER_W   = 7,
    parameter int ENTRY_W   = 8,
    parameter int DEPTH     = 36,
    parameter int WIN_SHIFT = 2,
    parameter int TEMP_OFS  = 40,
    localparam int IDX_W    = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_lut_en,
    input  logic                     cfg_adder,
    input  logic                     cfg_wiper_hold,
    input  logic                     cfg_addr_hold,
    input  logic                     cfg_standby,
    input  logic [WIPER_W-1:0]       init_val,
    input  logic                     temp_valid,
    input  logic signed [TEMP_W-1:0] temp_sample,
    input  logic                     tbl_wr_en,
    input  logic [IDX_W-1:0]         tbl_wr_idx,
    input  logic [ENTRY_W-1:0]       tbl_wr_data,
    input  logic [IDX_W-1:0]         tbl_rd_idx,
    output logic [ENTRY_W-1:0]       tbl_rd_data,
    input  logic                     addr_wr_en,
    input  logic [IDX_W-1:0]         addr_wr_data,
    output logic [IDX_W-1:0]         addr_q,
    input  logic                     wiper_wr_en,
    input  logic [WIPER_W-1:0]       wiper_wr_data,
    output logic [WIPER_W-1:0]       wiper_q
);
    wiper_mode_t        mode;
    logic               seen_q;
    logic               conv_ok;
    logic               addr_bus_ok;
    logic               wiper_bus_ok;
    logic [IDX_W-1:0]   next_idx;
    logic [IDX_W-1:0]   look_idx;
    logic [ENTRY_W-1:0] look_entry;
    logic [WIPER_W-1:0] calc_val;

    // Mode decode and acceptance qualifiers.
    always_comb begin
        mode         = decode_mode(cfg_lut_en, cfg_adder);
        conv_ok      = temp_valid && (mode != MODE_DIRECT) && !cfg_standby;
        addr_bus_ok  = addr_wr_en && cfg_addr_hold && (int'(addr_wr_data) < DEPTH);
        wiper_bus_ok = wiper_wr_en && ((mode == MODE_DIRECT) || cfg_wiper_hold);
        look_idx     = cfg_addr_hold ? addr_q : next_idx;
    end

    win_tracker #(
        .TEMP_W   (TEMP_W),
        .DEPTH    (DEPTH),
        .WIN_SHIFT(WIN_SHIFT),
        .TEMP_OFS (TEMP_OFS)
    ) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .temp_i    (temp_sample),
        .cur_idx_i (addr_q),
        .seen_i    (seen_q),
        .next_idx_o(next_idx)
    );

    lut_store #(
        .DEPTH  (DEPTH),
        .ENTRY_W(ENTRY_W)
    ) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (tbl_wr_en),
        .wr_idx (tbl_wr_idx),
        .wr_data(tbl_wr_data),
        .rd_idx (tbl_rd_idx),
        .rd_data(tbl_rd_data),
        .lk_idx (look_idx),
        .lk_data(look_entry)
    );

    wiper_calc #(
        .WIPER_W(WIPER_W),
        .ENTRY_W(ENTRY_W)
    ) u_calc (
        .mode_i (mode),
        .entry_i(look_entry),
        .base_i (init_val),
        .value_o(calc_val)
    );

    // Records that a sample has been accepted since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            seen_q <= 1'b0;
        else if (conv_ok)
            seen_q <= 1'b1;
    end

    // Table address register: bus write under hold, else temperature-driven.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (addr_bus_ok)
            addr_q <= addr_wr_data;
        else if (conv_ok && !cfg_addr_hold)
            addr_q <= next_idx;
    end

    // Wiper register: initial value at reset, bus write, or automatic load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wiper_q <= init_val;
        else if (wiper_bus_ok)
            wiper_q <= wiper_wr_data;
        else if (conv_ok && !cfg_wiper_hold)
            wiper_q <= calc_val;
    end

    // R3: the address register always points inside the table
    assert_addr_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(addr_q) < DEPTH);

    // R2: direct mode without a bus write leaves the wiper and address alone
    assert_direct_still_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_lut_en && !wiper_wr_en && !addr_wr_en) |=> ($stable(wiper_q) && $stable(addr_q)));

    // R7: a frozen wiper moves only through a bus write
    assert_wiper_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wiper_hold && !wiper_wr_en) |=> $stable(wiper_q));

    // R8: a frozen address moves only through a bus write
    assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr_hold && !addr_wr_en) |=> $stable(addr_q));

    // R9: standby blocks every temperature-driven change
    assert_standby_still_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_standby && !addr_wr_en && !wiper_wr_en) |=> ($stable(wiper_q) && $stable(addr_q)));

endmodule

// File: tb/sim_lut_wiper_ctrl.sv
module sim_lut_wiper_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_lut_en = 1'b0, cfg_adder = 1'b0, cfg_wiper_hold = 1'b0;
    logic       cfg_addr_hold = 1'b0, cfg_standby = 1'b0;
    logic [6:0] init_val = 7'd0;
    logic       temp_valid = 1'b0;
    logic signed [7:0] temp_sample = '0;
    logic       tbl_wr_en = 1'b0;
    logic [5:0] tbl_wr_idx = '0, tbl_rd_idx = '0;
    logic [7:0] tbl_wr_data = '0, tbl_rd_data;
    logic       addr_wr_en = 1'b0;
    logic [5:0] addr_wr_data = '0, addr_q;
    logic       wiper_wr_en = 1'b0;
    logic [6:0] wiper_wr_data = '0, wiper_q;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    lut_wiper_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_lut_en(cfg_lut_en), .cfg_adder(cfg_adder),
        .cfg_wiper_hold(cfg_wiper_hold), .cfg_addr_hold(cfg_addr_hold),
        .cfg_standby(cfg_standby), .init_val(init_val),
        .temp_valid(temp_valid), .temp_sample(temp_sample),
        .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx), .tbl_wr_data(tbl_wr_data),
        .tbl_rd_idx(tbl_rd_idx), .tbl_rd_data(tbl_rd_data),
        .addr_wr_en(addr_wr_en), .addr_wr_data(addr_wr_data), .addr_q(addr_q),
        .wiper_wr_en(wiper_wr_en), .wiper_wr_data(wiper_wr_data), .wiper_q(wiper_q)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic [6:0] iv);
        init_val = iv;
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    task automatic convert(input int t);
        temp_sample = 8'(t);
        temp_valid = 1'b1;
        tick();
        temp_valid = 1'b0;
    endtask

    task automatic tbl_write(input int idx, input int val);
        tbl_wr_idx = 6'(idx);
        tbl_wr_data = 8'(val);
        tbl_wr_en = 1'b1;
        tick();
        tbl_wr_en = 1'b0;
    endtask

    task automatic fill_table();
        for (int i = 0; i < 36; i++) tbl_write(i, i + 10);
    endtask

    task automatic bus_wiper(input int v);
        wiper_wr_data = 7'(v);
        wiper_wr_en = 1'b1;
        tick();
        wiper_wr_en = 1'b0;
    endtask

    task automatic bus_addr(input int v);
        addr_wr_data = 6'(v);
        addr_wr_en = 1'b1;
        tick();
        addr_wr_en = 1'b0;
    endtask

    task automatic set_mode(input logic lut, input logic add);
        cfg_lut_en = lut;
        cfg_adder = add;
        cfg_wiper_hold = 1'b0;
        cfg_addr_hold = 1'b0;
        cfg_standby = 1'b0;
    endtask

    // R1 reset state
    task automatic t_reset();
        set_mode(1'b0, 1'b0);
        do_reset(7'd42);
        chk("R1 wiper after reset", wiper_q, 42);
        chk("R1 addr after reset", addr_q, 0);
        tbl_rd_idx = 6'd7;
        #1;
        chk("R1 table cleared", tbl_rd_data, 0);
    endtask

    // R2 direct mode
    task automatic t_direct();
        set_mode(1'b0, 1'b0);
        do_reset(7'd20);
        fill_table();
        convert(60);
        chk("R2 sample ignores wiper", wiper_q, 20);
        chk("R2 sample ignores addr", addr_q, 0);
        bus_wiper(55);
        chk("R2 bus write wiper", wiper_q, 55);
    endtask

    // R3, R4, R5, R1 first sample: window mapping and hysteresis
    task automatic t_windows();
        set_mode(1'b1, 1'b0);
        do_reset(7'd0);
        fill_table();
        convert(25);
        chk("R1 first sample addr", addr_q, 16);
        chk("R5 plain wiper", wiper_q, 26);
        convert(27);
        chk("R4 stays below edge", addr_q, 16);
        convert(28);
        chk("R4 rise on even edge", addr_q, 17);
        chk("R5 wiper follows", wiper_q, 27);
        convert(27);
        chk("R4 hold at L-1 falling", addr_q, 17);
        convert(26);
        chk("R4 drop below L-1", addr_q, 16);
        convert(27);
        chk("R4 no rise at odd", addr_q, 16);
        convert(28);
        chk("R4 rise again", addr_q, 17);
        convert(100);
        chk("R3 clamp high", addr_q, 35);
        convert(-128);
        chk("R3 clamp low", addr_q, 0);
        convert(-36);
        chk("R3 mapping -36", addr_q, 1);
    endtask

    // R5 clip of large entries
    task automatic t_clip();
        set_mode(1'b1, 1'b0);
        do_reset(7'd0);
        tbl_write(16, 8'h90);
        convert(25);
        chk("R5 entry above 7Fh clips", wiper_q, 127);
    endtask

    // R6 adder mode
    task automatic t_adder();
        set_mode(1'b1, 1'b1);
        do_reset(7'd60);
        tbl_write(16, 8'hF0);
        tbl_write(17, 8'h50);
        tbl_write(18, 8'h9C);
        convert(25);
        chk("R6 negative offset", wiper_q, 44);
        convert(28);
        chk("R6 saturate high", wiper_q, 127);
        convert(32);
        chk("R6 saturate low", wiper_q, 0);
    endtask

    // R7 wiper hold
    task automatic t_wiper_hold();
        set_mode(1'b1, 1'b0);
        do_reset(7'd5);
        fill_table();
        bus_wiper(99);
        chk("R7 bus write ignored without hold", wiper_q, 5);
        cfg_wiper_hold = 1'b1;
        convert(25);
        chk("R7 sample no wiper load", wiper_q, 5);
        chk("R7 addr still updates", addr_q, 16);
        bus_wiper(77);
        chk("R7 bus write under hold", wiper_q, 77);
    endtask

    // R8 address hold
    task automatic t_addr_hold();
        set_mode(1'b1, 1'b0);
        do_reset(7'd0);
        fill_table();
        bus_addr(9);
        chk("R8 addr write ignored without hold", addr_q, 0);
        cfg_addr_hold = 1'b1;
        bus_addr(5);
        chk("R8 addr write under hold", addr_q, 5);
        bus_addr(50);
        chk("R8 out-of-range write ignored", addr_q, 5);
        convert(25);
        chk("R8 addr frozen", addr_q, 5);
        chk("R8 wiper uses held addr", wiper_q, 15);
    endtask

    // R9 standby
    task automatic t_standby();
        set_mode(1'b1, 1'b0);
        do_reset(7'd3);
        fill_table();
        convert(25);
        cfg_standby = 1'b1;
        convert(60);
        chk("R9 standby addr", addr_q, 16);
        chk("R9 standby wiper", wiper_q, 26);
        cfg_standby = 1'b0;
        tick();
        chk("R9 no change before sample", addr_q, 16);
        convert(60);
        chk("R9 resume addr", addr_q, 25);
        chk("R9 resume wiper", wiper_q, 35);
    endtask

    // R10 table port
    task automatic t_table();
        set_mode(1'b0, 1'b0);
        do_reset(7'd0);
        tbl_write(35, 8'hA5);
        tbl_write(40, 8'h33);
        tbl_rd_idx = 6'd35;
        #1;
        chk("R10 read back", tbl_rd_data, 8'hA5);
        tbl_rd_idx = 6'd40;
        #1;
        chk("R10 out-of-range read", tbl_rd_data, 0);
        tbl_rd_idx = 6'd8;
        #1;
        chk("R10 other entry untouched", tbl_rd_data, 0);
    endtask

    initial begin
        t_reset();
        t_direct();
        t_windows();
        t_clip();
        t_adder();
        t_wiper_hold();
        t_addr_hold();
        t_standby();
        t_table();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule